// File: doc/BRIEF.md
# Paged RAM Window Controller

This block sits between a host bus decoder and a large static RAM that is far bigger than the host's address window. The host sees a 32 KiB paged window whose contents come from one selectable 32 KiB page of the RAM. It also sees a second, non-paged window that is fixed on the highest page. The external decoder matches each window's base address and raises one select line per window. The block turns the select, the 15-bit window offset and the read or write strobe into a registered RAM byte address and registered strobes.

Software chooses the page in one of two ways. The first is a 32-bit native page register with byte-lane writes. A written value is clamped to the last page that the strapped memory size provides, so software can find the page count by writing all ones and reading the register back. The second is an 8-bit write-only compatibility page register. On the 160-page size this register folds its upper half onto the high 16 KiB halves of the first 128 pages. Whichever register was written last sets the mapping. A compatibility write also loads the native register with the page it translates to.

Top module: `paged_ram_window`

## Requirements
- R1: After synchronous reset the native page reads back 0, the compatibility fold is off, and both RAM strobes are low.
- R2: A paged-window read or write drives, one clock later, RAM address = page × 32768 + offset and the matching strobe for one cycle.
- R3: A native page write stores min(value, last), where last is 159 when size_sel is 0 and 287 when size_sel is 1. Writing 0xFFFFFFFF therefore reads back the last page.
- R4: In a native write, a byte lane whose pg_be bit is set takes the new byte. When pg_be[0] is set, every unselected upper lane becomes zero. When pg_be[0] is clear, unselected lanes keep their held value. Saturation is applied to the merged value.
- R5: With legacy_en set, a non-paged window access addresses last × 32768 + offset, whatever the current page.
- R6: With legacy_en clear, a non-paged window access produces no strobe.
- R7: With mem_en clear, no access on either window produces a strobe.
- R8: With size_sel 1, a compatibility write of n selects native page n, and the native register reads back n.
- R9: With size_sel 0, a compatibility write of n < 128 selects native page n with no fold.
- R10: With size_sel 0, a compatibility write of n ≥ 128 selects native page n−128 (read back as n−128) and forces offset bit 14 to 1, so that both halves of the window show the page's high 16 KiB.
- R11: A native write after a compatibility write cancels the fold, and the native value alone sets the mapping.
- R12: When both window selects are raised together, the paged window takes the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| size_sel | input | 1 | Memory size strap: 0 = 160 pages, 1 = 288 pages |
| legacy_en | input | 1 | Enables the non-paged window |
| mem_en | input | 1 | Memory-space enable from the configuration block |
| pg_wr | input | 1 | Native page register write strobe |
| pg_be | input | 4 | Byte-lane enables for the native write |
| pg_wdata | input | 32 | Native page write data |
| pg_rdata | output | 32 | Native page readback (zero-extended) |
| leg_wr | input | 1 | Compatibility page write strobe |
| leg_wdata | input | 8 | Compatibility page value |
| pw_sel | input | 1 | Paged window hit from the bus decoder |
| npw_sel | input | 1 | Non-paged window hit from the bus decoder |
| acc_rd | input | 1 | Window read strobe |
| acc_wr | input | 1 | Window write strobe |
| acc_off | input | 15 | Byte offset inside the window |
| sram_addr | output | 24 | Registered RAM byte address |
| sram_rd | output | 1 | Registered RAM read strobe |
| sram_wr | output | 1 | Registered RAM write strobe |

## Verification
Assertions check on every cycle that the stored page never goes past the strapped last page, that a write to the low byte alone can never leave a page above 255, that the half-page fold appears only on the small size, and that the enable gating and the fixed last-page target of the non-paged window hold. The exact result of a lane merge followed by saturation, the translation of compatibility pages, and the way the most recent writer decides the mapping show only in the bench's scenarios. These are read back through the register and seen in the RAM addresses that accesses produce.

// File: rtl/prw_pkg.sv
package prw_pkg;
  typedef enum logic [1:0] {
    WIN_NONE  = 2'd0,
    WIN_PAGED = 2'd1,
    WIN_FLAT  = 2'd2
  } win_e;

  function automatic int unsigned last_of(input logic big, input int unsigned small_n,
                                          input int unsigned big_n);
    return big ? (big_n - 1) : (small_n - 1);
  endfunction
endpackage

// File: rtl/prw_page_reg.sv
module prw_page_reg #(
  parameter int PAGES_SMALL = 160,
  parameter int PAGES_BIG   = 288,
  parameter int PAGE_W      = 9,
  parameter int REG_W       = 32,
  parameter int LEG_W       = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               size_sel,
  input  logic               pg_wr,
  input  logic [REG_W/8-1:0] pg_be,
  input  logic [REG_W-1:0]   pg_wdata,
  input  logic               leg_wr,
  input  logic [LEG_W-1:0]   leg_wdata,
  output logic [PAGE_W-1:0]  page_q,
  output logic               fold_q,
  output logic [PAGE_W-1:0]  last_pg
);
  import prw_pkg::*;

  localparam int NLANE = REG_W / 8;

  logic [REG_W-1:0] held;
  logic [REG_W-1:0] merged;
  logic [REG_W-1:0] last_w;
  logic [REG_W-1:0] clamped;
  logic [PAGE_W-1:0] leg_page;
  logic              leg_fold;

  assign last_w  = REG_W'(last_of(size_sel, PAGES_SMALL, PAGES_BIG));
  assign last_pg = last_w[PAGE_W-1:0];
  assign held    = {{(REG_W-PAGE_W){1'b0}}, page_q};

  // per-lane merge: low lane write zeroes untouched upper lanes
  for (genvar b = 0; b < NLANE; b++) begin : g_lane
    if (b == 0) begin : g_low
      assign merged[7:0] = pg_be[0] ? pg_wdata[7:0] : held[7:0];
    end else begin : g_high
      assign merged[b*8 +: 8] = pg_be[b] ? pg_wdata[b*8 +: 8] :
                                (pg_be[0] ? 8'h00 : held[b*8 +: 8]);
    end
  end

  assign clamped = (merged > last_w) ? last_w : merged;

  // compatibility translation
  always_comb begin
    leg_page = {{(PAGE_W-LEG_W){1'b0}}, leg_wdata};
    leg_fold = 1'b0;
    if (!size_sel && leg_wdata[LEG_W-1]) begin
      leg_page = {{(PAGE_W-LEG_W+1){1'b0}}, leg_wdata[LEG_W-2:0]};
      leg_fold = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q <= '0;
      fold_q <= 1'b0;
    end else if (pg_wr) begin
      page_q <= clamped[PAGE_W-1:0];
      fold_q <= 1'b0;
    end else if (leg_wr) begin
      page_q <= leg_page;
      fold_q <= leg_fold;
    end
  end

  // R3
  page_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    page_q <= last_pg);

  // R4
  lane0_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (pg_wr && pg_be == NLANE'(1)) |=> (page_q <= PAGE_W'(255)));

  // R10
  fold_small_only_chk: assert property (@(posedge clk) disable iff (rst)
    fold_q |-> !size_sel);
endmodule

// File: rtl/prw_addr_map.sv
module prw_addr_map #(
  parameter int PAGE_W = 9,
  parameter int OFF_W  = 15,
  parameter int ADDR_W = PAGE_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mem_en,
  input  logic              legacy_en,
  input  logic              pw_sel,
  input  logic              npw_sel,
  input  logic              acc_rd,
  input  logic              acc_wr,
  input  logic [OFF_W-1:0]  acc_off,
  input  logic [PAGE_W-1:0] page_q,
  input  logic              fold_q,
  input  logic [PAGE_W-1:0] last_pg,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_rd,
  output logic              sram_wr
);
  import prw_pkg::*;

  win_e              win;
  logic [OFF_W-1:0]  off_eff;
  logic [ADDR_W-1:0] addr_nxt;

  always_comb begin
    win = WIN_NONE;
    if (mem_en && (acc_rd || acc_wr)) begin
      if (pw_sel)                      win = WIN_PAGED;
      else if (npw_sel && legacy_en)   win = WIN_FLAT;
    end
  end

  assign off_eff = fold_q ? {1'b1, acc_off[OFF_W-2:0]} : acc_off;

  always_comb begin
    case (win)
      WIN_PAGED: addr_nxt = {page_q, off_eff};
      WIN_FLAT:  addr_nxt = {last_pg, acc_off};
      default:   addr_nxt = sram_addr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sram_addr <= '0;
      sram_rd   <= 1'b0;
      sram_wr   <= 1'b0;
    end else begin
      sram_addr <= addr_nxt;
      sram_rd   <= (win != WIN_NONE) && acc_rd;
      sram_wr   <= (win != WIN_NONE) && acc_wr;
    end
  end

  // R7
  mem_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_en |=> !(sram_rd || sram_wr));

  // R6
  flat_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!legacy_en && !pw_sel) |=> !(sram_rd || sram_wr));

  // R5
  flat_last_page_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_en && legacy_en && npw_sel && !pw_sel && acc_rd)
      |=> (sram_addr[ADDR_W-1:OFF_W] == $past(last_pg)));
endmodule

// File: rtl/paged_ram_window.sv
module paged_ram_window #(
  parameter int PAGES_SMALL = 160,
  parameter int PAGES_BIG   = 288,
  parameter int OFF_W       = 15,
  parameter int REG_W       = 32,
  parameter int LEG_W       = 8,
  parameter int PAGE_W      = $clog2(PAGES_BIG),
  parameter int ADDR_W      = PAGE_W + OFF_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               size_sel,
  input  logic               legacy_en,
  input  logic               mem_en,
  input  logic               pg_wr,
  input  logic [REG_W/8-1:0] pg_be,
  input  logic [REG_W-1:0]   pg_wdata,
  output logic [REG_W-1:0]   pg_rdata,
  input  logic               leg_wr,
  input  logic [LEG_W-1:0]   leg_wdata,
  input  logic               pw_sel,
  input  logic               npw_sel,
  input  logic               acc_rd,
  input  logic               acc_wr,
  input  logic [OFF_W-1:0]   acc_off,
  output logic [ADDR_W-1:0]  sram_addr,
  output logic               sram_rd,
  output logic               sram_wr
);
  logic [PAGE_W-1:0] page_q;
  logic [PAGE_W-1:0] last_pg;
  logic              fold_q;

  prw_page_reg #(
    .PAGES_SMALL(PAGES_SMALL), .PAGES_BIG(PAGES_BIG), .PAGE_W(PAGE_W),
    .REG_W(REG_W), .LEG_W(LEG_W)
  ) u_page (
    .clk(clk), .rst(rst), .size_sel(size_sel),
    .pg_wr(pg_wr), .pg_be(pg_be), .pg_wdata(pg_wdata),
    .leg_wr(leg_wr), .leg_wdata(leg_wdata),
    .page_q(page_q), .fold_q(fold_q), .last_pg(last_pg)
  );

  prw_addr_map #(.PAGE_W(PAGE_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W)) u_map (
    .clk(clk), .rst(rst), .mem_en(mem_en), .legacy_en(legacy_en),
    .pw_sel(pw_sel), .npw_sel(npw_sel), .acc_rd(acc_rd), .acc_wr(acc_wr),
    .acc_off(acc_off), .page_q(page_q), .fold_q(fold_q), .last_pg(last_pg),
    .sram_addr(sram_addr), .sram_rd(sram_rd), .sram_wr(sram_wr)
  );

  assign pg_rdata = {{(REG_W-PAGE_W){1'b0}}, page_q};
endmodule

// File: tb/paged_ram_window_bench.sv
module paged_ram_window_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        size_sel = 1'b0, legacy_en = 1'b1, mem_en = 1'b1;
  logic        pg_wr = 1'b0;
  logic [3:0]  pg_be = '0;
  logic [31:0] pg_wdata = '0;
  logic [31:0] pg_rdata;
  logic        leg_wr = 1'b0;
  logic [7:0]  leg_wdata = '0;
  logic        pw_sel = 1'b0, npw_sel = 1'b0, acc_rd = 1'b0, acc_wr = 1'b0;
  logic [14:0] acc_off = '0;
  logic [23:0] sram_addr;
  logic        sram_rd, sram_wr;

  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  paged_ram_window u_paged_ram_window (
    .clk(clk), .rst(rst), .size_sel(size_sel), .legacy_en(legacy_en),
    .mem_en(mem_en), .pg_wr(pg_wr), .pg_be(pg_be), .pg_wdata(pg_wdata),
    .pg_rdata(pg_rdata), .leg_wr(leg_wr), .leg_wdata(leg_wdata),
    .pw_sel(pw_sel), .npw_sel(npw_sel), .acc_rd(acc_rd), .acc_wr(acc_wr),
    .acc_off(acc_off), .sram_addr(sram_addr), .sram_rd(sram_rd), .sram_wr(sram_wr)
  );

  // {size_sel, be, data, expected page}
  localparam logic [68:0] VEC [13] = '{
    {1'b0, 4'hF, 32'hFFFF_FFFF, 32'd159},
    {1'b0, 4'h1, 32'h0000_0064, 32'd100},
    {1'b0, 4'h2, 32'h0000_0100, 32'd159},
    {1'b0, 4'h1, 32'h0000_009F, 32'd159},
    {1'b0, 4'h1, 32'h0000_00A0, 32'd159},
    {1'b1, 4'hF, 32'hFFFF_FFFF, 32'd287},
    {1'b1, 4'h1, 32'h0000_001F, 32'd31},
    {1'b1, 4'h2, 32'h0000_0100, 32'd287},
    {1'b1, 4'h1, 32'h0000_0005, 32'd5},
    {1'b1, 4'h4, 32'h0001_0000, 32'd287},
    {1'b1, 4'h1, 32'h0000_00FF, 32'd255},
    {1'b1, 4'h2, 32'h0000_FF00, 32'd287},
    {1'b1, 4'h1, 32'h0000_0000, 32'd0}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic do_reset(input logic big);
    @(negedge clk);
    size_sel = big;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic native_wr(input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    pg_wr = 1'b1; pg_be = be; pg_wdata = d;
    @(negedge clk);
    pg_wr = 1'b0; pg_be = '0;
  endtask

  task automatic compat_wr(input logic [7:0] d);
    @(negedge clk);
    leg_wr = 1'b1; leg_wdata = d;
    @(negedge clk);
    leg_wr = 1'b0;
  endtask

  task automatic access(input logic pw, input logic npw, input logic wr,
                        input logic [14:0] off, output logic got_rd,
                        output logic got_wr, output int got_addr);
    @(negedge clk);
    pw_sel = pw; npw_sel = npw; acc_rd = !wr; acc_wr = wr; acc_off = off;
    @(negedge clk);
    got_rd = sram_rd; got_wr = sram_wr; got_addr = int'(sram_addr);
    pw_sel = 1'b0; npw_sel = 1'b0; acc_rd = 1'b0; acc_wr = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic r, w;
    int a;

    // R1 reset state
    do_reset(1'b0);
    check("R1 page", int'(pg_rdata), 0);
    check("R1 rd", int'(sram_rd), 0);
    check("R1 wr", int'(sram_wr), 0);

    // R3/R4 table, each row also exercises R2
    for (int i = 0; i < 13; i++) begin
      if (i == 0 || VEC[i][68] != VEC[i-1][68]) do_reset(VEC[i][68]);
      native_wr(VEC[i][67:64], VEC[i][63:32]);
      check("R3/R4 readback", int'(pg_rdata), int'(VEC[i][31:0]));
      access(1'b1, 1'b0, 1'b0, 15'h1234, r, w, a);
      check("R2 addr", a, int'(VEC[i][31:0]) * 32768 + 'h1234);
      check("R2 rd", int'(r), 1);
    end

    // R2 write strobe
    do_reset(1'b1);
    native_wr(4'h1, 32'd9);
    access(1'b1, 1'b0, 1'b1, 15'h7FFF, r, w, a);
    check("R2 wr", int'(w), 1);
    check("R2 rd low on write", int'(r), 0);
    check("R2 wr addr", a, 9 * 32768 + 'h7FFF);

    // R5 non-paged window, both sizes
    access(1'b0, 1'b1, 1'b0, 15'h0042, r, w, a);
    check("R5 big addr", a, 287 * 32768 + 'h42);
    check("R5 rd", int'(r), 1);
    do_reset(1'b0);
    native_wr(4'h1, 32'd3);
    access(1'b0, 1'b1, 1'b0, 15'h0100, r, w, a);
    check("R5 small addr", a, 159 * 32768 + 'h100);

    // R6 non-paged ignored with legacy off
    legacy_en = 1'b0;
    access(1'b0, 1'b1, 1'b0, 15'h0200, r, w, a);
    check("R6 rd", int'(r), 0);
    access(1'b0, 1'b1, 1'b1, 15'h0200, r, w, a);
    check("R6 wr", int'(w), 0);
    legacy_en = 1'b1;

    // R7 memory enable clear
    mem_en = 1'b0;
    access(1'b1, 1'b0, 1'b0, 15'h0010, r, w, a);
    check("R7 paged rd", int'(r), 0);
    access(1'b0, 1'b1, 1'b1, 15'h0010, r, w, a);
    check("R7 flat wr", int'(w), 0);
    mem_en = 1'b1;

    // R9 small, direct compatibility page
    compat_wr(8'd100);
    check("R9 readback", int'(pg_rdata), 100);
    access(1'b1, 1'b0, 1'b0, 15'h0123, r, w, a);
    check("R9 addr", a, 100 * 32768 + 'h123);

    // R10 small, folded upper half
    compat_wr(8'd130);
    check("R10 readback", int'(pg_rdata), 2);
    access(1'b1, 1'b0, 1'b0, 15'h0123, r, w, a);
    check("R10 low half addr", a, 2 * 32768 + 'h4123);
    access(1'b1, 1'b0, 1'b0, 15'h4567, r, w, a);
    check("R10 high half addr", a, 2 * 32768 + 'h4567);

    // R11 native write cancels the fold
    native_wr(4'h1, 32'd7);
    access(1'b1, 1'b0, 1'b0, 15'h0123, r, w, a);
    check("R11 addr", a, 7 * 32768 + 'h123);

    // R12 paged window wins when both selected
    access(1'b1, 1'b1, 1'b0, 15'h0055, r, w, a);
    check("R12 addr", a, 7 * 32768 + 'h55);

    // R8 big, one-to-one compatibility pages
    do_reset(1'b1);
    compat_wr(8'd200);
    check("R8 readback", int'(pg_rdata), 200);
    access(1'b1, 1'b0, 1'b0, 15'h0123, r, w, a);
    check("R8 addr", a, 200 * 32768 + 'h123);
    compat_wr(8'd255);
    check("R8 readback 255", int'(pg_rdata), 255);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule